// File: doc/BRIEF.md
# Write-Protected I2C Configuration Register Target

This block is an I2C target that gives a host read and write access to a small bank of 8-bit configuration registers. It answers to a single fixed 7-bit address. After the address byte, a write carries a register-pointer byte and then any number of data bytes. Each data byte lands in the register the pointer names, and the pointer then steps to the next register. A read is started with a repeated START after the pointer byte, or with no pointer byte at all, in which case it continues from wherever the pointer was left. Reads return one byte per host acknowledge and stop at the host's NACK.

SCL and SDA are oversampled by a faster system clock through a two-flop synchroniser. START, STOP and SCL edges are derived from the synchronised lines. The block drives SDA open-drain through an output-enable that pulls the line low. The pointer runs from 0x00 to 0x0A and then returns to 0x00. Three configuration registers stay frozen after reset until their own enable bit is set in a separate enable register. Writes to a frozen register are acknowledged and thrown away.

Top module: `i2c_cfg_target`

## Requirements
- R1: The block acknowledges the address byte 0x50 (write) and 0x51 (read), which is 7-bit address 0x28 with the direction in bit 0. Any other address byte gets no acknowledge, and the block leaves SDA released until the next START.
- R2: In a write, the block acknowledges the address byte, the pointer byte and every data byte. Each data byte is stored in the register the pointer names, on the SCL falling edge after its eighth bit.
- R3: After each data byte is written, the pointer advances by one, so consecutive bytes go to consecutive registers.
- R4: The pointer advances from 0x0A to 0x00. This holds for writes and for reads.
- R5: A read started by a repeated START after a pointer byte returns the addressed register first. The bits come one per SCL clock, MSB first.
- R6: During a read, a host ACK after a byte makes the block send the following register. A host NACK makes the block release SDA until a STOP or START.
- R7: A read with no pointer byte starts at the current pointer value. That value is the register after the last byte written or read.
- R8: Registers 0x05, 0x06 and 0x07 accept writes only while bit 5, 6 or 7 of register 0x08 is 1. Bit 5 unlocks 0x05, bit 6 unlocks 0x06 and bit 7 unlocks 0x07. A write to a locked register is acknowledged and discarded, and the pointer still advances.
- R9: Registers 0x09 and 0x0A acknowledge writes but keep nothing. They always read as 0x00.
- R10: After reset, every register reads 0x00, so all three locks are engaged.
- R11: A pointer byte of 0x0B or above sets the pointer to 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, several times faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | When 1, pulls SDA low; when 0, SDA is released |

## Verification
The hardest case to reach is the lock on registers 0x05 to 0x07. The only way to see a discarded write is to read the register back later, and the pointer must still have advanced past it. The stimulus runs one write burst that crosses all three locked registers and lands in the enable register. It then writes to the locked registers again with only some enable bits set, and reads back the whole span. A read that starts in the reserved area runs through the wrap into register 0x00. The pointer it leaves behind is then checked with a current-address read.

// File: rtl/i2c_cfg_pkg.sv
package i2c_cfg_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_RX,
        S_ACK,
        S_TX,
        S_TXACK,
        S_SKIP
    } bus_st_e;

    typedef enum logic [1:0] {
        K_DEV,
        K_REG,
        K_DATA
    } rx_kind_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int W = STAGES + 1;

    logic [W-1:0] scl_sh_d, scl_sh_q;
    logic [W-1:0] sda_sh_d, sda_sh_q;
    logic scl_s, scl_p, sda_p;

    always_comb begin
        scl_sh_d = {scl_sh_q[W-2:0], scl_i};
        sda_sh_d = {sda_sh_q[W-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_sh_q <= '1;
            sda_sh_q <= '1;
        end else begin
            scl_sh_q <= scl_sh_d;
            sda_sh_q <= sda_sh_d;
        end
    end

    assign scl_s     = scl_sh_q[STAGES-1];
    assign scl_p     = scl_sh_q[STAGES];
    assign sda_s     = sda_sh_q[STAGES-1];
    assign sda_p     = sda_sh_q[STAGES];
    assign scl_rise  = scl_s && !scl_p;
    assign scl_fall  = !scl_s && scl_p;
    assign start_det = scl_s && scl_p && sda_p && !sda_s;
    assign stop_det  = scl_s && scl_p && !sda_p && sda_s;
endmodule

// File: rtl/i2c_cfg_bank.sv
module i2c_cfg_bank #(
    parameter int NREG    = 11,
    parameter int WEN_IDX = 8,
    parameter int LOCK_LO = 5,
    parameter int LOCK_HI = 7,
    parameter int RSV_LO  = 9,
    localparam int AW     = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] waddr,
    input  logic [7:0]    wdata,
    input  logic [AW-1:0] raddr,
    output logic [7:0]    rdata
);
    logic [NREG-1:0][7:0] bank_d, bank_q;
    logic [NREG-1:0]      wok;

    // per-slot write permission: locked, reserved or open
    for (genvar g = 0; g < NREG; g++) begin : g_slot
        if (g >= LOCK_LO && g <= LOCK_HI) begin : g_lock
            assign wok[g] = bank_q[WEN_IDX][g];
            // R8: a write to a locked slot leaves it unchanged
            p_lock_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && waddr == AW'(g) && !bank_q[WEN_IDX][g]) |=> $stable(bank_q[g]));
        end else if (g >= RSV_LO) begin : g_rsv
            assign wok[g] = 1'b0;
        end else begin : g_open
            assign wok[g] = 1'b1;
        end
    end

    always_comb begin
        bank_d = bank_q;
        for (int i = 0; i < NREG; i++) begin
            if (wr_en && waddr == AW'(i) && wok[i]) bank_d[i] = wdata;
        end
        rdata = '0;
        if (raddr < AW'(NREG)) rdata = bank_q[raddr];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) bank_q <= '0;
        else        bank_q <= bank_d;
    end

    // R2: the enable register always takes the written byte
    p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && waddr == AW'(WEN_IDX)) |=> bank_q[WEN_IDX] == $past(wdata));
    // R9: reserved slots read as zero
    p_rsv_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (raddr >= AW'(RSV_LO) && raddr < AW'(NREG)) |-> rdata == 8'h00);
endmodule

// File: rtl/i2c_cfg_target.sv
module i2c_cfg_target
    import i2c_cfg_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h28,
    parameter int NREG        = 11,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_oe
);
    localparam int AW = $clog2(NREG);
    localparam logic [AW-1:0] LAST = AW'(NREG - 1);

    typedef struct packed {
        bus_st_e       st;
        rx_kind_e      kind;
        logic [3:0]    cnt;
        logic [7:0]    sh;
        logic [AW-1:0] ptr;
        logic          rd;
        logic          hack;
        logic          oe;
    } ctl_t;

    ctl_t c_d, c_q;
    logic sda_s, scl_rise, scl_fall, start_det, stop_det;
    logic wr_pulse;
    logic [7:0] rdata;
    logic [AW-1:0] ptr_nxt;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .start_det(start_det), .stop_det(stop_det)
    );

    i2c_cfg_bank #(.NREG(NREG)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_pulse), .waddr(c_q.ptr),
        .wdata(c_q.sh), .raddr(c_q.ptr), .rdata(rdata)
    );

    assign ptr_nxt = (c_q.ptr == LAST) ? '0 : c_q.ptr + 1'b1;

    always_comb begin
        c_d      = c_q;
        wr_pulse = 1'b0;
        if (stop_det) begin
            c_d.st = S_IDLE;
            c_d.oe = 1'b0;
        end else if (start_det) begin
            c_d.st   = S_RX;
            c_d.kind = K_DEV;
            c_d.cnt  = '0;
            c_d.oe   = 1'b0;
        end else begin
            case (c_q.st)
                S_RX: begin
                    if (scl_rise && c_q.cnt < 4'd8) begin
                        c_d.sh  = {c_q.sh[6:0], sda_s};
                        c_d.cnt = c_q.cnt + 4'd1;
                    end else if (scl_fall && c_q.cnt == 4'd8) begin
                        c_d.cnt = '0;
                        c_d.oe  = 1'b1;
                        c_d.st  = S_ACK;
                        case (c_q.kind)
                            K_DEV: begin
                                if (c_q.sh[7:1] != DEV_ADDR) begin
                                    c_d.oe = 1'b0;
                                    c_d.st = S_SKIP;
                                end else begin
                                    c_d.rd = c_q.sh[0];
                                end
                            end
                            K_REG: c_d.ptr = (c_q.sh < 8'(NREG)) ? c_q.sh[AW-1:0] : '0;
                            default: begin
                                wr_pulse = 1'b1;
                                c_d.ptr  = ptr_nxt;
                            end
                        endcase
                    end
                end
                S_ACK: begin
                    if (scl_fall) begin
                        c_d.oe  = 1'b0;
                        c_d.cnt = '0;
                        if (c_q.kind == K_DEV && c_q.rd) begin
                            c_d.st = S_TX;
                            c_d.sh = rdata;
                            c_d.oe = ~rdata[7];
                        end else begin
                            c_d.st   = S_RX;
                            c_d.kind = (c_q.kind == K_DEV) ? K_REG : K_DATA;
                        end
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        if (c_q.cnt == 4'd7) begin
                            c_d.st  = S_TXACK;
                            c_d.oe  = 1'b0;
                            c_d.ptr = ptr_nxt;
                        end else begin
                            c_d.sh  = {c_q.sh[6:0], 1'b0};
                            c_d.oe  = ~c_q.sh[6];
                            c_d.cnt = c_q.cnt + 4'd1;
                        end
                    end
                end
                S_TXACK: begin
                    if (scl_rise) begin
                        c_d.hack = ~sda_s;
                    end else if (scl_fall) begin
                        if (c_q.hack) begin
                            c_d.st  = S_TX;
                            c_d.cnt = '0;
                            c_d.sh  = rdata;
                            c_d.oe  = ~rdata[7];
                        end else begin
                            c_d.st = S_SKIP;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: S_IDLE, kind: K_DEV, cnt: '0, sh: '0, ptr: '0,
                     rd: 1'b0, hack: 1'b0, oe: 1'b0};
        end else begin
            c_q <= c_d;
        end
    end

    assign sda_oe = c_q.oe;

    // R4: a data byte written at the last slot leaves the pointer at zero
    p_ptr_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_pulse && c_q.ptr == LAST) |=> c_q.ptr == '0);
    // R6: SDA is free after a STOP
    p_release_on_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> !sda_oe);
    // R1: a foreign address byte is never acknowledged
    p_nack_foreign_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (c_q.st == S_RX && c_q.kind == K_DEV && scl_fall && c_q.cnt == 4'd8
         && c_q.sh[7:1] != DEV_ADDR) |=> (!sda_oe && c_q.st == S_SKIP));
endmodule

// File: tb/i2c_cfg_target_test.sv
module i2c_cfg_target_test;
    localparam int Q = 8;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1;
    logic m_low = 1'b0;
    logic sda_oe;
    logic sda_line;
    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;
    item_t exp_q[$];
    item_t act_q[$];

    always #10 clk = ~clk;
    assign sda_line = !(sda_oe || m_low);

    i2c_cfg_target uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b1; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic bit_out(input logic b);
        m_low = !b; tick(Q);
        scl = 1'b1; tick(2 * Q);
        scl = 1'b0; tick(Q);
    endtask

    task automatic bit_in(output logic b);
        m_low = 1'b0; tick(Q);
        scl = 1'b1;   tick(Q);
        b = sda_line; tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    // driver: push expected, then produce the observed item
    task automatic wbyte(input logic [7:0] b, input logic exp_ack, input string tag);
        logic a;
        exp_q.push_back('{{7'b0, exp_ack}, tag});
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(a);
        act_q.push_back('{{7'b0, !a}, tag});
    endtask

    task automatic rbyte(input logic [7:0] expv, input logic last, input string tag);
        logic [7:0] v;
        logic b;
        exp_q.push_back('{expv, tag});
        for (int i = 7; i >= 0; i--) begin
            bit_in(b);
            v[i] = b;
        end
        act_q.push_back('{v, tag});
        bit_out(last);
    endtask

    task automatic set_ptr_read(input logic [7:0] r, input string tag);
        bus_start();
        wbyte(8'h50, 1'b1, tag);
        wbyte(r, 1'b1, tag);
        bus_start();
        wbyte(8'h51, 1'b1, tag);
    endtask

    // monitor: pops and compares as results appear
    initial begin
        forever begin
            @(negedge clk);
            while (act_q.size() > 0) begin
                item_t a, e;
                a = act_q.pop_front();
                e = exp_q.pop_front();
                n_cmp++;
                if (a.v !== e.v) begin
                    n_bad++;
                    $display("FAIL %s: actual %02h expected %02h", e.tag, a.v, e.v);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual still running, expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic b;
        tick(4);
        // R10: reset state, nothing on the bus yet
        exp_q.push_back('{8'h00, "R10 sda_oe idle"});
        act_q.push_back('{{7'b0, sda_oe}, "R10 sda_oe idle"});
        rst_n = 1'b1;
        tick(4);

        // R10 R5: registers start at zero, locks engaged
        set_ptr_read(8'h07, "R5 random read");
        rbyte(8'h00, 1'b0, "R10 reg07 reset");
        rbyte(8'h00, 1'b1, "R10 reg08 reset");
        bus_stop();

        // R1: a foreign address is ignored until START
        bus_start();
        wbyte(8'h52, 1'b0, "R1 foreign address nack");
        wbyte(8'h00, 1'b0, "R1 ignored after foreign");
        bus_stop();

        // R2 R3: burst write 0x00..0x04
        bus_start();
        wbyte(8'h50, 1'b1, "R1 own address ack");
        wbyte(8'h00, 1'b1, "R2 pointer ack");
        for (int i = 0; i < 5; i++) wbyte(8'hA0 + 8'(i), 1'b1, "R2 data ack");
        bus_stop();

        // R5 R6 R3: read back with continuation
        set_ptr_read(8'h00, "R5 random read");
        for (int i = 0; i < 5; i++)
            rbyte(8'hA0 + 8'(i), (i == 4), "R3 R6 burst readback");
        // R6: after NACK the line stays released
        bit_in(b);
        exp_q.push_back('{8'h01, "R6 released after nack"});
        act_q.push_back('{{7'b0, b}, "R6 released after nack"});
        bus_stop();

        // R8: burst crosses locked registers into the enable register
        bus_start();
        wbyte(8'h50, 1'b1, "R8");
        wbyte(8'h04, 1'b1, "R8");
        wbyte(8'h44, 1'b1, "R8 open write ack");
        wbyte(8'h55, 1'b1, "R8 locked write ack");
        wbyte(8'h66, 1'b1, "R8 locked write ack");
        wbyte(8'h77, 1'b1, "R8 locked write ack");
        wbyte(8'h80, 1'b1, "R8 enable write ack");
        bus_stop();
        set_ptr_read(8'h04, "R8");
        rbyte(8'h44, 1'b0, "R8 reg04");
        rbyte(8'h00, 1'b0, "R8 reg05 locked");
        rbyte(8'h00, 1'b0, "R8 reg06 locked");
        rbyte(8'h00, 1'b0, "R8 reg07 locked");
        rbyte(8'h80, 1'b1, "R8 reg08 enables");
        bus_stop();

        // R8: only bit 7 set, so only 0x07 unlocks
        bus_start();
        wbyte(8'h50, 1'b1, "R8");
        wbyte(8'h05, 1'b1, "R8");
        wbyte(8'h55, 1'b1, "R8");
        wbyte(8'h66, 1'b1, "R8");
        wbyte(8'h77, 1'b1, "R8");
        bus_stop();
        set_ptr_read(8'h05, "R8");
        rbyte(8'h00, 1'b0, "R8 reg05 still locked");
        rbyte(8'h00, 1'b0, "R8 reg06 still locked");
        rbyte(8'h77, 1'b1, "R8 reg07 unlocked");
        bus_stop();

        // R8: enable bits 6 and 5
        bus_start();
        wbyte(8'h50, 1'b1, "R8");
        wbyte(8'h08, 1'b1, "R8");
        wbyte(8'h60, 1'b1, "R8");
        bus_stop();
        bus_start();
        wbyte(8'h50, 1'b1, "R8");
        wbyte(8'h05, 1'b1, "R8");
        wbyte(8'h55, 1'b1, "R8");
        wbyte(8'h66, 1'b1, "R8");
        bus_stop();
        set_ptr_read(8'h05, "R8");
        rbyte(8'h55, 1'b0, "R8 reg05 unlocked");
        rbyte(8'h66, 1'b0, "R8 reg06 unlocked");
        rbyte(8'h77, 1'b1, "R8 reg07 kept");
        bus_stop();

        // R9 R4: writes to reserved slots, then wrap into 0x00
        bus_start();
        wbyte(8'h50, 1'b1, "R9");
        wbyte(8'h09, 1'b1, "R9");
        wbyte(8'h99, 1'b1, "R9 reserved write ack");
        wbyte(8'hAA, 1'b1, "R9 reserved write ack");
        wbyte(8'hBB, 1'b1, "R4 wrapped write ack");
        bus_stop();
        set_ptr_read(8'h09, "R9");
        rbyte(8'h00, 1'b0, "R9 reg09 zero");
        rbyte(8'h00, 1'b0, "R9 reg0A zero");
        rbyte(8'hBB, 1'b1, "R4 read wrap to reg00");
        bus_stop();

        // R7: current-address read continues at 0x01
        bus_start();
        wbyte(8'h51, 1'b1, "R7 current read ack");
        rbyte(8'hA1, 1'b0, "R7 current read reg01");
        rbyte(8'hA2, 1'b1, "R7 current read reg02");
        bus_stop();

        // R11: out-of-range pointer lands on 0x00
        bus_start();
        wbyte(8'h50, 1'b1, "R11");
        wbyte(8'h20, 1'b1, "R11 pointer ack");
        bus_stop();
        bus_start();
        wbyte(8'h51, 1'b1, "R11");
        rbyte(8'hBB, 1'b1, "R11 pointer clamped to reg00");
        bus_stop();

        tick(8);
        if (exp_q.size() != 0) begin
            n_cmp++;
            n_bad++;
            $display("FAIL scoreboard: actual %0d unmatched, expected 0", exp_q.size());
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule